// File: doc/BRIEF.md
# Two-Pass Residue Conversion Sequencer

This block is the digital controller for one row of a first-order, single-bit oversampling converter. It builds an 8-bit result in two counting passes, where a plain single-bit scheme would need 256 cycles. Each cycle the comparator delivers one decision bit. During a 16-cycle coarse pass the block counts the ones in that stream, and the count becomes the upper nibble. The block then latches that nibble, clears its counter and raises a feedback select. That select tells the analog front end to resample the integrator residue instead of a fresh input. A second 16-cycle pass then produces the lower nibble.

A single-cycle start pulse launches a conversion. After the 32 counting cycles the block holds off for 18 idle cycles, so conversions repeat on a fixed 50-cycle period. Each nibble is presented with a one-cycle latch strobe. An output-enable level marks when the read-out nibble is valid. A one-cycle done pulse coincides with the full word {upper, lower}. The pass length, the nibble width, the number of passes and the idle gap are all parameters. This allows, for example, 5+5 bits over 64 cycles, or 3+3+3 bits over 24 cycles with the feedback select raised for every pass after the first.

Top module: `residue_adc_seq`

## Requirements
- R1: While reset is high and on the cycle after it, busy, fb_sel, latch_en, out_en and done are 0, and nib_out and result are 0.
- R2: A start sampled high while idle begins a conversion. busy is 1 from the next cycle on. The decision bits sampled at the following 16 rising edges form the coarse pass, and the 16 edges after those form the fine pass.
- R3: On the edge that samples the 16th decision of a pass, nib_out takes the number of ones seen in that pass. latch_en is 1 for exactly that one cycle.
- R4: A pass with 16 one-decisions yields 15. The count saturates and does not wrap to 0.
- R5: fb_sel is 0 throughout the coarse pass. It is 1 for exactly the 16 cycles of the fine pass, starting on the cycle the coarse nibble is latched, and 0 otherwise.
- R6: The counter is cleared between passes, so the lower nibble counts only fine-pass decisions.
- R7: done is a one-cycle pulse on the edge that samples the 32nd decision. On that pulse, result equals {coarse nibble, fine nibble}, with the coarse nibble in bits 7:4. result holds its value until the next done.
- R8: out_en rises together with the first latch_en of a conversion. It stays 1 until the next accepted start, and it is 0 on the cycle after that start.
- R9: After done, busy stays 1 for 18 more cycles and then returns to 0, giving a 50-cycle conversion period. A start sampled during a conversion or during the idle gap is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (accepted only when idle) |
| dec_bit | input | 1 | Comparator decision for this cycle |
| fb_sel | output | 1 | Resample integrator residue instead of new input |
| latch_en | output | 1 | One-cycle strobe: nib_out was just updated |
| nib_out | output | 4 | Most recently latched nibble |
| out_en | output | 1 | Read-out nibble of current conversion is valid |
| done | output | 1 | One-cycle strobe: result holds a complete word |
| result | output | 8 | {coarse nibble, fine nibble} |
| busy | output | 1 | Conversion or idle gap in progress |

## Verification
The conversion is driven with decision streams whose two passes differ in how many ones they contain. The streams used are all zeros, all ones, a silent coarse pass followed by a full fine pass, alternating patterns, and single-one or single-zero passes. These separate a correct count from a wrap at 16, and from a counter that is not cleared between passes. They also catch swapped nibble order. Because the coarse pass ends full in one vector and empty in another, a count leaking from the coarse pass into the fine pass shows up directly. Start pulses are injected during the fine pass and throughout the idle gap, and busy is then timed to the edge. This shows that no stray start shortens the 50-cycle period or corrupts the word.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DEF_PASS_LEN   = 16;
    localparam int DEF_NIB_W      = 4;
    localparam int DEF_NUM_PASSES = 2;
    localparam int DEF_GAP_CYCLES = 18;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic start_acc;
        logic counting;
        logic pass_end;
        logic last_pass;
    } seq_ctrl_t;

    function automatic int width_of(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
    import adc_seq_pkg::*;
#(
    parameter int PASS_LEN   = DEF_PASS_LEN,
    parameter int NUM_PASSES = DEF_NUM_PASSES,
    parameter int GAP_CYCLES = DEF_GAP_CYCLES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output seq_ctrl_t  ctrl,
    output seq_state_e state,
    output logic       fb_sel
);
    localparam int CYC_W  = width_of(PASS_LEN);
    localparam int PASS_W = width_of(NUM_PASSES);
    localparam int GAP_W  = width_of(GAP_CYCLES);
    localparam logic [CYC_W-1:0]  LAST_CYC  = CYC_W'(PASS_LEN - 1);
    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NUM_PASSES - 1);
    localparam logic [GAP_W-1:0]  LAST_GAP  = GAP_W'(GAP_CYCLES - 1);

    logic [CYC_W-1:0]  cyc;
    logic [PASS_W-1:0] pass_idx;
    logic [GAP_W-1:0]  gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cyc      <= '0;
            pass_idx <= '0;
            gap      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_CONV;
                        cyc      <= '0;
                        pass_idx <= '0;
                    end
                end
                ST_CONV: begin
                    if (cyc == LAST_CYC) begin
                        cyc <= '0;
                        if (pass_idx == LAST_PASS) begin
                            state    <= ST_GAP;
                            pass_idx <= '0;
                            gap      <= '0;
                        end else begin
                            pass_idx <= pass_idx + 1'b1;
                        end
                    end else begin
                        cyc <= cyc + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (gap == LAST_GAP) state <= ST_IDLE;
                    else                 gap   <= gap + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctrl.start_acc = (state == ST_IDLE) && start;
        ctrl.counting  = (state == ST_CONV);
        ctrl.pass_end  = (state == ST_CONV) && (cyc == LAST_CYC);
        ctrl.last_pass = (pass_idx == LAST_PASS);
        fb_sel         = (state == ST_CONV) && (pass_idx != '0);
    end

    // R9
    gap_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |=> (state != ST_CONV));

    // R2
    conv_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> (state == ST_CONV));

endmodule

// File: rtl/adc_seq_ones_cnt.sv
module adc_seq_ones_cnt
    import adc_seq_pkg::*;
#(
    parameter int NIB_W = DEF_NIB_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    input  logic             dec,
    output logic [NIB_W-1:0] cnt_q,
    output logic [NIB_W-1:0] cnt_sum
);
    localparam logic [NIB_W-1:0] CNT_MAX = {NIB_W{1'b1}};

    always_comb begin
        if (dec && cnt_q == CNT_MAX) cnt_sum = CNT_MAX;
        else                         cnt_sum = cnt_q + NIB_W'(dec);
    end

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (en)  cnt_q <= clr ? '0 : cnt_sum;
    end

    // R4
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    // R6
    pass_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (en && clr) |=> (cnt_q == '0));

endmodule

// File: rtl/adc_seq_nibble_latch.sv
module adc_seq_nibble_latch
    import adc_seq_pkg::*;
#(
    parameter int NIB_W      = DEF_NIB_W,
    parameter int NUM_PASSES = DEF_NUM_PASSES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  seq_ctrl_t                   ctrl,
    input  logic [NIB_W-1:0]            cnt_sum,
    output logic [NIB_W-1:0]            nib_out,
    output logic                        latch_en,
    output logic                        out_en,
    output logic                        done,
    output logic [NIB_W*NUM_PASSES-1:0] result
);
    localparam int RES_W = NIB_W * NUM_PASSES;

    logic [RES_W-1:0] acc;
    logic [RES_W-1:0] acc_next;

    generate
        if (NUM_PASSES == 1) begin : g_single
            assign acc_next = cnt_sum;
        end else begin : g_multi
            assign acc_next = {acc[RES_W-NIB_W-1:0], cnt_sum};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            nib_out  <= '0;
            latch_en <= 1'b0;
            out_en   <= 1'b0;
            done     <= 1'b0;
            result   <= '0;
            acc      <= '0;
        end else begin
            latch_en <= ctrl.pass_end;
            done     <= ctrl.pass_end && ctrl.last_pass;
            if (ctrl.start_acc)     out_en <= 1'b0;
            else if (ctrl.pass_end) out_en <= 1'b1;
            if (ctrl.pass_end) begin
                nib_out <= cnt_sum;
                acc     <= acc_next;
                if (ctrl.last_pass) result <= acc_next;
            end
        end
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    latch_single_chk: assert property (@(posedge clk) disable iff (rst)
        latch_en |=> !latch_en);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

endmodule

// File: rtl/residue_adc_seq.sv
module residue_adc_seq
    import adc_seq_pkg::*;
#(
    parameter int PASS_LEN   = DEF_PASS_LEN,
    parameter int NIB_W      = DEF_NIB_W,
    parameter int NUM_PASSES = DEF_NUM_PASSES,
    parameter int GAP_CYCLES = DEF_GAP_CYCLES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic                        dec_bit,
    output logic                        fb_sel,
    output logic                        latch_en,
    output logic [NIB_W-1:0]            nib_out,
    output logic                        out_en,
    output logic                        done,
    output logic [NIB_W*NUM_PASSES-1:0] result,
    output logic                        busy
);
    seq_ctrl_t        ctrl;
    seq_state_e       state;
    logic [NIB_W-1:0] cnt_q;
    logic [NIB_W-1:0] cnt_sum;

    adc_seq_timer #(
        .PASS_LEN  (PASS_LEN),
        .NUM_PASSES(NUM_PASSES),
        .GAP_CYCLES(GAP_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctrl  (ctrl),
        .state (state),
        .fb_sel(fb_sel)
    );

    adc_seq_ones_cnt #(
        .NIB_W(NIB_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .en     (ctrl.counting),
        .clr    (ctrl.pass_end),
        .dec    (dec_bit),
        .cnt_q  (cnt_q),
        .cnt_sum(cnt_sum)
    );

    adc_seq_nibble_latch #(
        .NIB_W     (NIB_W),
        .NUM_PASSES(NUM_PASSES)
    ) u_latch (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .cnt_sum (cnt_sum),
        .nib_out (nib_out),
        .latch_en(latch_en),
        .out_en  (out_en),
        .done    (done),
        .result  (result)
    );

    assign busy = (state != ST_IDLE);

    // R5
    fb_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fb_sel) |-> latch_en);

    // R7
    done_fb_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (latch_en && !fb_sel));

    // R8
    out_en_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_en) |-> latch_en);

    // R2
    count_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cnt_q == '0));

endmodule

// File: tb/test_residue_adc_seq.sv
module test_residue_adc_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       dec_bit = 1'b0;
    logic       fb_sel, latch_en, out_en, done, busy;
    logic [3:0] nib_out;
    logic [7:0] result;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    residue_adc_seq i_residue_adc_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .dec_bit (dec_bit),
        .fb_sel  (fb_sel),
        .latch_en(latch_en),
        .nib_out (nib_out),
        .out_en  (out_en),
        .done    (done),
        .result  (result),
        .busy    (busy)
    );

    // upper half: coarse-pass decisions, lower half: fine-pass; bit k = cycle k
    localparam int NVEC = 6;
    localparam logic [31:0] VECS [NVEC] = '{
        32'h0000_0000,
        32'hFFFF_FFFF,
        32'h0000_FFFF,
        32'hAAAA_5555,
        32'h7FFF_0001,
        32'h8421_FFFE
    };

    function automatic int sat_count(input logic [15:0] bits);
        int c = $countones(bits);
        return (c > 15) ? 15 : c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_conv(input logic [31:0] vec, input bit inject);
        logic [15:0] p1 = vec[31:16];
        logic [15:0] p2 = vec[15:0];
        int hi = sat_count(p1);
        int lo = sat_count(p2);
        @(negedge clk);
        chk(!busy, "R9 idle before start", busy, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R2 busy after start", busy, 1);
        chk(!out_en, "R8 out_en cleared by start", out_en, 0);
        for (int k = 0; k < 16; k++) begin
            chk(!fb_sel, "R5 fb_sel low in coarse pass", fb_sel, 0);
            if (k == 8) chk(!latch_en, "R3 no strobe mid pass", latch_en, 0);
            dec_bit = p1[k];
            @(negedge clk);
        end
        chk(latch_en, "R3 coarse strobe", latch_en, 1);
        chk(nib_out == 4'(hi), "R3 R4 coarse nibble", nib_out, hi);
        chk(out_en, "R8 out_en with first strobe", out_en, 1);
        for (int k = 0; k < 16; k++) begin
            chk(fb_sel, "R5 fb_sel high in fine pass", fb_sel, 1);
            chk(!done, "R7 no early done", done, 0);
            dec_bit = p2[k];
            start = inject;
            @(negedge clk);
        end
        start = 1'b0;
        dec_bit = 1'b0;
        chk(done, "R7 done strobe", done, 1);
        chk(result == 8'((hi << 4) | lo), "R6 R7 result word", result, (hi << 4) | lo);
        chk(nib_out == 4'(lo), "R6 fine nibble", nib_out, lo);
        chk(!fb_sel, "R5 fb_sel low after fine pass", fb_sel, 0);
        start = inject;
        for (int g = 0; g < 17; g++) @(negedge clk);
        start = 1'b0;
        chk(!done, "R7 done single cycle", done, 0);
        chk(busy, "R9 busy through gap", busy, 1);
        chk(result == 8'((hi << 4) | lo), "R7 result held", result, (hi << 4) | lo);
        @(negedge clk);
        chk(!busy, "R9 idle after 50 cycles", busy, 0);
        chk(out_en, "R8 out_en held until start", out_en, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !fb_sel && !latch_en && !out_en && !done, "R1 reset controls",
            {busy, fb_sel, latch_en, out_en, done}, 0);
        chk(nib_out == 0 && result == 0, "R1 reset data", result, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && result == 0, "R1 after reset", result, 0);
        for (int v = 0; v < NVEC; v++) run_conv(VECS[v], 1'b0);
        run_conv(32'h0F0F_3C3C, 1'b1);
        run_conv(32'hFFFF_0000, 1'b1);
        @(negedge clk);
        chk(!busy, "R9 no start left pending", busy, 0);
        rst = 1'b1;
        @(negedge clk);
        chk(result == 0 && !out_en, "R1 mid-run reset", result, 0);
        rst = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule